// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a binary down counter (8 bits by default) with an active-low zero flag. On each rising clock edge it steps down by one while its active-low enable is asserted. It can be preset from a parallel word in two ways: through a load that takes effect at the next rising edge, or through a load that acts at once without waiting for the clock. A separate active-low clear forces the counter to its all-ones maximum at once. Every control input and the zero flag are active-low.

Below zero the counter wraps to the maximum, so a free-running counter has a period of 2^WIDTH clock edges. The zero flag is asserted only while the count is zero and the enable is asserted. Feeding that flag into the enable of a second counter chains the two into a wider counter. The chain can share one clock, or it can be built as a ripple chain.

Top module: `preset_down_counter`

## Requirements
- R1: While `clr_n` is 0, `count_q` equals all ones (255 at the default width) at once, without a clock edge, whatever the level of every other input.
- R2: While `clr_n` is 1 and `async_ld_n` is 0, `count_q` equals `preset_word` at once, without a clock edge, whatever the levels of `sync_ld_n`, `cnt_en_n` and `clk`.
- R3: With `clr_n` and `async_ld_n` at 1 and `sync_ld_n` at 0, a rising edge loads `preset_word` into the count, whether `cnt_en_n` is 0 or 1.
- R4: With `clr_n`, `async_ld_n` and `sync_ld_n` at 1 and `cnt_en_n` at 0, each rising edge lowers the count by exactly one.
- R5: With `clr_n`, `async_ld_n`, `sync_ld_n` and `cnt_en_n` all at 1, the count holds its value across rising edges.
- R6: A count of 0 that is decremented becomes all ones, so a counter that keeps counting returns to the same value every 256 edges (2^WIDTH).
- R7: `term_n` is 0 exactly when the count is 0 and `cnt_en_n` is 0. It follows `cnt_en_n` with no clock delay.
- R8: After `async_ld_n` or `clr_n` returns to 1, the count keeps the forced value until the next rising edge, and normal synchronous operation resumes from that edge.
- R9: Two counters share a clock, and the `term_n` of the low counter drives the `cnt_en_n` of the high counter. Started from all ones, the pair steps down one 16-bit value per edge and repeats every 65536 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| preset_word | input | WIDTH | Parallel preset value |
| cnt_en_n | input | 1 | Active-low count enable |
| sync_ld_n | input | 1 | Active-low preset, taken at the next rising edge |
| async_ld_n | input | 1 | Active-low preset, takes effect at once |
| clr_n | input | 1 | Active-low clear to all ones, takes effect at once, highest priority |
| count_q | output | WIDTH | Present count |
| term_n | output | 1 | Active-low zero flag, gated by `cnt_en_n` |

## Verification
Counting, holding and the synchronous load show at `count_q` one rising edge after the controls are set. The clear, the asynchronous load and the zero flag show with no clock edge at all. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next edge for the clocked results. For the immediate results it samples 1 ns after changing the input, before any edge. The asynchronous controls are always held low across at least one rising edge, so the clocked assertions never see a forced value appear between two edges.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // Step chosen by the synchronous controls at a rising edge.
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_COUNT = 2'd1,
    STEP_LOAD  = 2'd2
  } step_e;
endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
(
  input  logic  cnt_en_n,
  input  logic  sync_ld_n,
  input  logic  async_ld_n,
  input  logic  clr_n,
  output step_e step,
  output logic  forced,
  output logic  force_clr
);
  // The clear wins over every other control. The immediate load wins over the
  // synchronous controls. The synchronous load wins over the enable.
  assign force_clr = !clr_n;
  assign forced    = !clr_n || !async_ld_n;

  always_comb begin
    if (!sync_ld_n)     step = STEP_LOAD;
    else if (!cnt_en_n) step = STEP_COUNT;
    else                step = STEP_HOLD;
  end
endmodule

// File: rtl/pdc_state.sv
module pdc_state
  import pdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             async_ld_n,
  input  logic [WIDTH-1:0] preset_word,
  input  step_e            step,
  input  logic             forced,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] step_down(input logic [WIDTH-1:0] v);
    return v - {{(WIDTH-1){1'b0}}, 1'b1};
  endfunction

  logic [WIDTH-1:0] q_reg;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    case (step)
      STEP_LOAD:  q_nxt = preset_word;
      STEP_COUNT: q_nxt = step_down(q_reg);
      default:    q_nxt = q_reg;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n or negedge async_ld_n) begin
    if (!clr_n)           q_reg <= TOP;
    else if (!async_ld_n) q_reg <= preset_word;
    else                  q_reg <= q_nxt;
  end

  // The forced value shows at the output while a control is held, with no edge.
  assign q = !clr_n ? TOP : (!async_ld_n ? preset_word : q_reg);

  p_count_r4: assert property (@(posedge clk) disable iff (forced)
    step == STEP_COUNT |=> q == step_down($past(q)));
  p_hold_r5: assert property (@(posedge clk) disable iff (forced)
    step == STEP_HOLD |=> $stable(q));
  p_sync_load_r3: assert property (@(posedge clk) disable iff (forced)
    step == STEP_LOAD |=> q == $past(preset_word));
  p_wrap_r6: assert property (@(posedge clk) disable iff (forced)
    (step == STEP_COUNT && q == '0) |=> q == TOP);
endmodule

// File: rtl/pdc_term.sv
module pdc_term #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q,
  input  logic             cnt_en_n,
  output logic             at_zero,
  output logic             term_n
);
  function automatic logic is_empty(input logic [WIDTH-1:0] v);
    return ~|v;
  endfunction

  assign at_zero = is_empty(q);
  assign term_n  = !(at_zero && !cnt_en_n);
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter
  import pdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] preset_word,
  input  logic             cnt_en_n,
  input  logic             sync_ld_n,
  input  logic             async_ld_n,
  input  logic             clr_n,
  output logic [WIDTH-1:0] count_q,
  output logic             term_n
);
  step_e step;
  logic  forced;
  logic  force_clr;
  logic  at_zero;

  pdc_ctrl u_ctrl (
    .cnt_en_n  (cnt_en_n),
    .sync_ld_n (sync_ld_n),
    .async_ld_n(async_ld_n),
    .clr_n     (clr_n),
    .step      (step),
    .forced    (forced),
    .force_clr (force_clr)
  );

  pdc_state #(.WIDTH(WIDTH)) u_state (
    .clk        (clk),
    .clr_n      (clr_n),
    .async_ld_n (async_ld_n),
    .preset_word(preset_word),
    .step       (step),
    .forced     (forced),
    .q          (count_q)
  );

  pdc_term #(.WIDTH(WIDTH)) u_term (
    .q       (count_q),
    .cnt_en_n(cnt_en_n),
    .at_zero (at_zero),
    .term_n  (term_n)
  );

  p_clear_r1: assert property (@(posedge clk)
    force_clr |-> count_q == {WIDTH{1'b1}});
  p_async_load_r2: assert property (@(posedge clk) disable iff (force_clr)
    !async_ld_n |-> count_q == preset_word);
  p_flag_r7: assert property (@(posedge clk) disable iff (force_clr)
    !term_n |-> (at_zero && !cnt_en_n));
  p_release_r8: assert property (@(posedge clk) disable iff (forced)
    $rose(async_ld_n) |-> count_q == $past(preset_word));
endmodule

// File: tb/test_preset_down_counter.sv
`timescale 1ns/1ps
module test_preset_down_counter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] preset_word = '0;
  logic         cnt_en_n = 1'b1, sync_ld_n = 1'b1, async_ld_n = 1'b1, clr_n = 1'b0;
  logic [W-1:0] count_q;
  logic         term_n;
  logic [W-1:0] hi_preset = '0;
  logic         hi_sync_n = 1'b1, hi_async_n = 1'b1, hi_clr_n = 1'b0;
  logic [W-1:0] hi_count;
  logic         hi_term_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  preset_down_counter #(.WIDTH(W)) i_preset_down_counter (
    .clk(clk), .preset_word(preset_word), .cnt_en_n(cnt_en_n),
    .sync_ld_n(sync_ld_n), .async_ld_n(async_ld_n), .clr_n(clr_n),
    .count_q(count_q), .term_n(term_n));

  preset_down_counter #(.WIDTH(W)) i_hi_stage (
    .clk(clk), .preset_word(hi_preset), .cnt_en_n(term_n),
    .sync_ld_n(hi_sync_n), .async_ld_n(hi_async_n), .clr_n(hi_clr_n),
    .count_q(hi_count), .term_n(hi_term_n));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits for a rising edge, then 1 ns more: a safe point to sample and drive.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic sload(input logic [W-1:0] v);
    preset_word = v; sync_ld_n = 1'b0; tick(1); sync_ld_n = 1'b1;
  endtask

  task automatic t_reset();
    tick(2);
    check("R1 clear value", count_q, 255);
    check("R7 flag idle", term_n, 1);
    preset_word = 8'h12; sync_ld_n = 1'b0; cnt_en_n = 1'b0; tick(1);
    check("R1 clear beats sync load and enable", count_q, 255);
    sync_ld_n = 1'b1; cnt_en_n = 1'b1;
    clr_n = 1'b1; tick(1);
    check("R1 hold after release", count_q, 255);
  endtask

  task automatic t_count_hold();
    sload(8'd10);
    check("R3 load with enable high", count_q, 10);
    cnt_en_n = 1'b0; tick(3);
    check("R4 three decrements", count_q, 7);
    cnt_en_n = 1'b1; tick(4);
    check("R5 hold", count_q, 7);
    cnt_en_n = 1'b0; preset_word = 8'h5A; sync_ld_n = 1'b0; tick(1);
    sync_ld_n = 1'b1;
    check("R3 load beats enable", count_q, 8'h5A);
    cnt_en_n = 1'b1;
  endtask

  task automatic t_flag_wrap();
    sload(8'd2);
    cnt_en_n = 1'b0; tick(1);
    check("R7 flag high at one", term_n, 1);
    tick(1);
    check("R4 reached zero", count_q, 0);
    check("R7 flag low at zero", term_n, 0);
    cnt_en_n = 1'b1; #1;
    check("R7 flag follows enable", term_n, 1);
    cnt_en_n = 1'b0; #1;
    check("R7 flag back low", term_n, 0);
    tick(1);
    check("R6 wrap to max", count_q, 255);
    check("R7 flag one period only", term_n, 1);
    tick(255);
    check("R6 zero after 255 more", count_q, 0);
    tick(1);
    check("R6 period 256", count_q, 255);
    cnt_en_n = 1'b1;
  endtask

  task automatic t_async();
    sload(8'd100);
    preset_word = 8'h33; sync_ld_n = 1'b0; cnt_en_n = 1'b0; #1;
    async_ld_n = 1'b0; #1;
    check("R2 immediate load", count_q, 8'h33);
    tick(2);
    check("R2 beats clock, enable and sync load", count_q, 8'h33);
    clr_n = 1'b0; #1;
    check("R1 clear beats async load", count_q, 255);
    tick(1);
    clr_n = 1'b1; #1;
    check("R2 load shows after clear release", count_q, 8'h33);
    tick(1);
    sync_ld_n = 1'b1;
    async_ld_n = 1'b1; #1;
    check("R8 value kept after release", count_q, 8'h33);
    tick(1);
    check("R8 counting resumes at edge", count_q, 8'h32);
    clr_n = 1'b0; #1; tick(1);
    clr_n = 1'b1; #1;
    check("R8 clear value kept after release", count_q, 255);
    tick(1);
    check("R8 count after clear release", count_q, 254);
    cnt_en_n = 1'b1;
  endtask

  task automatic t_cascade();
    cnt_en_n = 1'b1;
    clr_n = 1'b0; hi_clr_n = 1'b0; tick(1);
    clr_n = 1'b1; hi_clr_n = 1'b1;
    check("R9 start value", {hi_count, count_q}, 65535);
    cnt_en_n = 1'b0;
    tick(256);
    check("R9 after 256 edges", {hi_count, count_q}, 65279);
    tick(65279);
    check("R9 reached zero", {hi_count, count_q}, 0);
    check("R9 high flag at zero", hi_term_n, 1'b0);
    tick(1);
    check("R9 period 65536", {hi_count, count_q}, 65535);
    cnt_en_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_count_hold();
    t_flag_wrap();
    t_async();
    t_cascade();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule